// File: doc/BRIEF.md
# NAND Hamming Parity Generator

This block builds a single-error-correcting Hamming code over one 512-byte data block while the bytes travel across a NAND data bus. The bus can be 8 or 16 bits wide. A one-cycle start strobe clears every accumulator, latches the bus width for the whole block and arms the generator. Each valid beat then folds one byte into the parities in 8-bit mode, or two bytes in 16-bit mode. After the last byte of the block, a done flag rises and the result stays frozen until the next start.

The result comes out in two forms. The raw parity word holds twelve even parities and twelve odd parities in fixed halves of a 32-bit word. The three-byte storage code is an inverted, interleaved repacking of the same parities, meant to be written to the spare area and later compared against a freshly generated code. Because the code is inverted, an all-zero block produces all-ones code bytes.

Top module: `hamming_ecc_gen`

## Requirements
- R1: While `start` is high, the next clock edge sets `parity_word` to 0, `ecc_code` to 24'hFFFFFF and `done` to 0, and latches `wide_sel`: 0 selects 8-bit beats, 1 selects 16-bit beats.
- R2: For each distance bit index k in 0..2, even parity `parity_word[k]` is the XOR of every data bit whose bit index within its byte has bit k clear. Odd parity `parity_word[16+k]` is the XOR of every data bit whose bit index has bit k set.
- R3: For each byte-address bit j in 0..8, even parity `parity_word[3+j]` is the XOR of every bit of the bytes whose address (0..511) has bit j clear. Odd parity `parity_word[19+j]` covers the bytes whose address has bit j set. Bits 12 to 15 and 28 to 31 of `parity_word` are always 0.
- R4: Writing Ek for `parity_word[k]` and Ok for `parity_word[16+k]`, the code fields are, from MSB to LSB:
  - `ecc_code[7:0]` = ~{O6,E6,O5,E5,O4,E4,O3,E3}
  - `ecc_code[15:8]` = ~{O10,E10,O9,E9,O8,E8,O7,E7}
  - `ecc_code[23:16]` = ~{O2,E2,O1,E1,O0,E0,O11,E11}
- R5: In 8-bit mode each valid beat carries the byte at the next address on `beat_data[7:0]`. `beat_data[15:8]` has no effect.
- R6: In 16-bit mode each valid beat carries address n on `beat_data[7:0]` and address n+1 on `beat_data[15:8]`, so 256 beats complete the block.
- R7: `done` goes to 1 at the clock edge that absorbs the 512th byte, so it reads 1 on the cycle after the final beat is presented. It stays 1 until the next `start`.
- R8: A beat is ignored when `beat_valid` is low, when `done` is 1, or before the first `start` after reset. In each case the parities stay unchanged.
- R9: A beat presented in the same cycle as `start` is not absorbed.
- R10: After reset, `parity_word` is 0, `done` is 0 and `ecc_code` is 24'hFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Clear accumulators, latch width and arm for a new block |
| wide_sel | input | 1 | Bus width, sampled with start: 0 = 8-bit, 1 = 16-bit |
| beat_valid | input | 1 | Data beat present |
| beat_data | input | 16 | Beat data; low byte first |
| parity_word | output | 32 | Even parities in bits 11:0, odd parities in bits 27:16 |
| ecc_code | output | 24 | Packed inverted code, byte 0 in bits 7:0 |
| done | output | 1 | Block complete, result frozen |

## Verification
The bench drives single-bit blocks at address 0 bit 0 and at address 511 bit 7. These catch a swapped even/odd half, a wrong packing order in the code bytes, and a missing inversion. Random blocks in both widths, with idle gaps and garbage on the idle or unused byte lane, expose designs that absorb invalid beats or mix the upper byte into an 8-bit run. A 16-bit design that placed the high byte at the even address would produce wrong bit-0 row parities. Beats sent after completion, before the first start, and in the same cycle as start would change the frozen parities in a design that failed to gate them. A done flag that rose one byte early or late shows up at the sample taken just before the final beat and the one taken just after it.

// File: rtl/ecc_pkg.sv
// Shared constants and types for the Hamming parity generator.
// Assumes byte-wide lanes; the bus carries one or two lanes per beat.
package ecc_pkg;
    localparam int LANE_BITS  = 8;
    localparam int BIT_LEVELS = 3;   // log2 of LANE_BITS
    localparam int MAX_LANES  = 2;

    typedef enum logic {
        WIDTH_8  = 1'b0,
        WIDTH_16 = 1'b1
    } bus_width_e;
endpackage

// File: rtl/byte_lane_parity.sv
// Parity contribution of one byte at a known address.
// Produces the even/odd terms for bit-index levels first and address levels next;
// all outputs are zero when the lane is not enabled this cycle.
module byte_lane_parity
    import ecc_pkg::*;
#(
    parameter int ADDR_BITS = 9,
    localparam int NP = BIT_LEVELS + ADDR_BITS
) (
    input  logic [LANE_BITS-1:0] byte_i,
    input  logic [ADDR_BITS-1:0] addr_i,
    input  logic                 en_i,
    output logic [NP-1:0]        even_o,
    output logic [NP-1:0]        odd_o
);
    logic byte_xor;

    // Fold the byte into column and row terms.
    always_comb begin
        byte_xor = ^byte_i;
        even_o   = '0;
        odd_o    = '0;
        for (int k = 0; k < BIT_LEVELS; k++) begin
            for (int i = 0; i < LANE_BITS; i++) begin
                if (((i >> k) & 1) == 1) odd_o[k]  = odd_o[k]  ^ byte_i[i];
                else                     even_o[k] = even_o[k] ^ byte_i[i];
            end
        end
        for (int j = 0; j < ADDR_BITS; j++) begin
            even_o[BIT_LEVELS+j] = byte_xor & ~addr_i[j];
            odd_o[BIT_LEVELS+j]  = byte_xor &  addr_i[j];
        end
        if (!en_i) begin
            even_o = '0;
            odd_o  = '0;
        end
    end
endmodule

// File: rtl/parity_accum.sv
// Beat sequencing and parity accumulation for one data block.
// Assumes start is a single-cycle strobe and 16-bit runs begin at an even address.
module parity_accum
    import ecc_pkg::*;
#(
    parameter int BLOCK_BYTES = 512,
    localparam int ADDR_BITS = $clog2(BLOCK_BYTES),
    localparam int NP        = BIT_LEVELS + ADDR_BITS,
    localparam int CNT_W     = ADDR_BITS + 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic                           wide_sel,
    input  logic                           beat_valid,
    input  logic [MAX_LANES*LANE_BITS-1:0] beat_data,
    output logic [NP-1:0]                  even_acc,
    output logic [NP-1:0]                  odd_acc,
    output logic                           done
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BLOCK_BYTES);

    bus_width_e             width_q;
    logic                   armed_q;
    logic [CNT_W-1:0]       cnt_q;
    logic [CNT_W-1:0]       cnt_nxt;
    logic                   take;
    logic [NP-1:0]          lane_even [MAX_LANES];
    logic [NP-1:0]          lane_odd  [MAX_LANES];
    logic [NP-1:0]          beat_even;
    logic [NP-1:0]          beat_odd;

    assign take    = armed_q & ~done & beat_valid & ~start;
    assign cnt_nxt = cnt_q + ((width_q == WIDTH_16) ? CNT_W'(2) : CNT_W'(1));

    // One parity lane per byte of the bus.
    for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
        logic [ADDR_BITS-1:0] lane_addr;
        logic                 lane_en;
        assign lane_addr = cnt_q[ADDR_BITS-1:0] | ADDR_BITS'(g);
        assign lane_en   = take & ((g == 0) || (width_q == WIDTH_16));
        byte_lane_parity #(.ADDR_BITS(ADDR_BITS)) u_lane (
            .byte_i (beat_data[g*LANE_BITS +: LANE_BITS]),
            .addr_i (lane_addr),
            .en_i   (lane_en),
            .even_o (lane_even[g]),
            .odd_o  (lane_odd[g])
        );
    end

    // Merge the lane contributions of this beat.
    always_comb begin
        beat_even = '0;
        beat_odd  = '0;
        for (int g = 0; g < MAX_LANES; g++) begin
            beat_even = beat_even ^ lane_even[g];
            beat_odd  = beat_odd  ^ lane_odd[g];
        end
    end

    // Sequencing state: arm, width, byte count, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            width_q <= WIDTH_8;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else if (start) begin
            armed_q <= 1'b1;
            width_q <= bus_width_e'(wide_sel);
            cnt_q   <= '0;
            done    <= 1'b0;
        end else if (take) begin
            cnt_q <= cnt_nxt;
            done  <= (cnt_nxt == LAST_CNT);
        end
    end

    // Parity accumulators.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            even_acc <= '0;
            odd_acc  <= '0;
        end else begin
            even_acc <= even_acc ^ beat_even;
            odd_acc  <= odd_acc  ^ beat_odd;
        end
    end
endmodule

// File: rtl/code_packer.sv
// Repacks the twelve parity pairs into three inverted storage bytes.
// Assumes exactly twelve pairs (a 512-byte block); purely combinational.
module code_packer #(
    parameter int NP = 12
) (
    input  logic [NP-1:0] even_i,
    input  logic [NP-1:0] odd_i,
    output logic [23:0]   code_o
);
    logic [2*NP-1:0] pairs;   // {odd_k, even_k} per level, level 0 lowest

    // Interleave each level as odd above even.
    always_comb begin
        for (int k = 0; k < NP; k++) begin
            pairs[2*k]   = even_i[k];
            pairs[2*k+1] = odd_i[k];
        end
    end

    // Byte 0: levels 6..3, byte 1: levels 10..7, byte 2: levels 2..0 then 11.
    assign code_o[7:0]   = ~pairs[13:6];
    assign code_o[15:8]  = ~pairs[21:14];
    assign code_o[23:16] = ~{pairs[5:0], pairs[23:22]};
endmodule

// File: rtl/hamming_ecc_gen.sv
// Top of the Hamming parity generator: accumulator plus code packing.
// Presents the raw parities in fixed 16-bit halves and the inverted storage code.
module hamming_ecc_gen
    import ecc_pkg::*;
#(
    parameter int BLOCK_BYTES = 512,
    localparam int ADDR_BITS = $clog2(BLOCK_BYTES),
    localparam int NP        = BIT_LEVELS + ADDR_BITS,
    localparam int HALF      = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        wide_sel,
    input  logic        beat_valid,
    input  logic [15:0] beat_data,
    output logic [31:0] parity_word,
    output logic [23:0] ecc_code,
    output logic        done
);
    logic [NP-1:0] even_acc;
    logic [NP-1:0] odd_acc;

    parity_accum #(.BLOCK_BYTES(BLOCK_BYTES)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .wide_sel   (wide_sel),
        .beat_valid (beat_valid),
        .beat_data  (beat_data),
        .even_acc   (even_acc),
        .odd_acc    (odd_acc),
        .done       (done)
    );

    code_packer #(.NP(NP)) u_pack (
        .even_i (even_acc),
        .odd_i  (odd_acc),
        .code_o (ecc_code)
    );

    // Raw word: even half low, odd half high, unused bits zero.
    assign parity_word = {{(HALF-NP){1'b0}}, odd_acc, {(HALF-NP){1'b0}}, even_acc};
endmodule

// File: rtl/hamming_ecc_gen_checker.sv
// Port-level temporal checks for the Hamming parity generator.
module hamming_ecc_gen_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        beat_valid,
    input logic [31:0] parity_word,
    input logic [23:0] ecc_code,
    input logic        done
);
    p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (parity_word == 32'h0) && !done && (ecc_code == 24'hFFFFFF));

    p_code_byte0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_code[7:0] == ~{parity_word[22], parity_word[6], parity_word[21], parity_word[5],
                           parity_word[20], parity_word[4], parity_word[19], parity_word[3]});

    p_code_byte2_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_code[23:16] == ~{parity_word[18], parity_word[2], parity_word[17], parity_word[1],
                             parity_word[16], parity_word[0], parity_word[27], parity_word[11]});

    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_frozen_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> $stable(parity_word));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_valid && !start) |=> $stable(parity_word));

    p_done_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past(start));
endmodule

bind hamming_ecc_gen hamming_ecc_gen_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .beat_valid  (beat_valid),
    .parity_word (parity_word),
    .ecc_code    (ecc_code),
    .done        (done)
);

// File: tb/tb_hamming_ecc_gen.sv
module tb_hamming_ecc_gen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        wide_sel;
    logic        beat_valid;
    logic [15:0] beat_data;
    logic [31:0] parity_word;
    logic [23:0] ecc_code;
    logic        done;

    int checks   = 0;
    int failures = 0;
    logic [7:0] blk [512];

    always #2 clk = ~clk;

    hamming_ecc_gen dut (
        .clk(clk), .rst_n(rst_n), .start(start), .wide_sel(wide_sel),
        .beat_valid(beat_valid), .beat_data(beat_data),
        .parity_word(parity_word), .ecc_code(ecc_code), .done(done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected raw parity word from the block contents.
    function automatic logic [31:0] model_raw();
        logic [31:0] r = '0;
        for (int a = 0; a < 512; a++) begin
            for (int i = 0; i < 8; i++) begin
                if (blk[a][i]) begin
                    for (int k = 0; k < 3; k++) begin
                        if ((i >> k) & 1) r[16+k] = ~r[16+k];
                        else              r[k]    = ~r[k];
                    end
                    for (int j = 0; j < 9; j++) begin
                        if ((a >> j) & 1) r[19+j] = ~r[19+j];
                        else              r[3+j]  = ~r[3+j];
                    end
                end
            end
        end
        return r;
    endfunction

    function automatic logic [23:0] model_code(input logic [31:0] r);
        logic [11:0] e = r[11:0];
        logic [11:0] o = r[27:16];
        logic [7:0] b0 = ~{o[6], e[6], o[5], e[5], o[4], e[4], o[3], e[3]};
        logic [7:0] b1 = ~{o[10], e[10], o[9], e[9], o[8], e[8], o[7], e[7]};
        logic [7:0] b2 = ~{o[2], e[2], o[1], e[1], o[0], e[0], o[11], e[11]};
        return {b2, b1, b0};
    endfunction

    task automatic idle();
        @(negedge clk);
        start = 0; beat_valid = 0; beat_data = 16'($urandom);
    endtask

    // Run one block; optional junk beat alongside start (R9), random gaps (R8).
    task automatic run_block(input bit wide, input bit junk_on_start, input int gap_pct);
        logic [31:0] exp_raw;
        int beats = wide ? 256 : 512;
        @(negedge clk);
        start = 1; wide_sel = wide;
        beat_valid = junk_on_start; beat_data = 16'hFFFF;
        for (int b = 0; b < beats; b++) begin
            while (($urandom % 100) < gap_pct) begin
                @(negedge clk);
                start = 0; beat_valid = 0; beat_data = 16'($urandom);
            end
            @(negedge clk);
            start = 0;
            if (b == 0) begin
                check("R1 cleared after start", parity_word, 32'h0);
                check("R1 code after start", {8'h0, ecc_code}, 32'h00FFFFFF);
            end
            if (b == beats - 1) check("R7 done low before final beat", {31'h0, done}, 32'h0);
            beat_valid = 1;
            if (wide) beat_data = {blk[2*b+1], blk[2*b]};
            else      beat_data = {8'($urandom), blk[b]};   // R5 upper lane is noise
        end
        idle();
        exp_raw = model_raw();
        check("R7 done after final beat", {31'h0, done}, 32'h1);
        check(wide ? "R6 raw parity 16-bit" : "R5 raw parity 8-bit", parity_word, exp_raw);
        check("R4 packed code", {8'h0, ecc_code}, {8'h0, model_code(exp_raw)});
        check("R3 unused bits zero", {28'h0, parity_word[31:28]} | {28'h0, parity_word[15:12]}, 32'h0);
        // R8: beats after done are ignored
        @(negedge clk);
        beat_valid = 1; beat_data = 16'hA5C3;
        @(negedge clk);
        beat_valid = 1; beat_data = 16'h0001;
        idle();
        check("R8 frozen after done", parity_word, exp_raw);
        check("R7 done held", {31'h0, done}, 32'h1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; start = 0; wide_sel = 0; beat_valid = 0; beat_data = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R10 reset parity", parity_word, 32'h0);
        check("R10 reset code", {8'h0, ecc_code}, 32'h00FFFFFF);
        check("R10 reset done", {31'h0, done}, 32'h0);
        // R8: beats before any start are ignored
        @(negedge clk); beat_valid = 1; beat_data = 16'h00FF;
        @(negedge clk); beat_valid = 1; beat_data = 16'h8001;
        idle();
        check("R8 no absorb before start", parity_word, 32'h0);

        // R2/R3: bit 0 of address 0 only
        foreach (blk[a]) blk[a] = 8'h00;
        blk[0] = 8'h01;
        run_block(0, 0, 0);
        check("R2 single bit addr0 raw", parity_word, 32'h00000FFF);
        check("R4 single bit addr0 code", {8'h0, ecc_code}, 32'h00AAAAAA);

        // R3: bit 7 of address 511, 16-bit bus
        foreach (blk[a]) blk[a] = 8'h00;
        blk[511] = 8'h80;
        run_block(1, 0, 0);
        check("R3 single bit addr511 raw", parity_word, 32'h0FFF0000);
        check("R4 single bit addr511 code", {8'h0, ecc_code}, 32'h00555555);

        // R6: odd address in high lane
        foreach (blk[a]) blk[a] = 8'h00;
        blk[1] = 8'h01;
        run_block(1, 1, 10);   // R9 junk beat alongside start

        // All-zero block
        foreach (blk[a]) blk[a] = 8'h00;
        run_block(0, 1, 0);
        check("R4 zero block code", {8'h0, ecc_code}, 32'h00FFFFFF);

        // Random blocks in both widths with gaps
        for (int n = 0; n < 6; n++) begin
            foreach (blk[a]) blk[a] = 8'($urandom);
            run_block(n[0], n[1], 25);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule